// File: doc/BRIEF.md
# NAND Asynchronous Bus Cycle Generator

This block turns simple host requests into the strobe sequences of an asynchronous NAND flash interface. The host issues one request at a time on a valid/ready port. The request address chooses one of several chip-select windows and an operation inside that window: a command-latch write, an address-latch write, a data write or a data read. The block then drives the chip enables, the command-latch and address-latch enables, the write and read strobes, and the tristate control of the 8-bit data bus. When the cycle is over it returns a response on a second valid/ready port.

Every phase of a bus cycle lasts a whole number of clock ticks. The tick counts come from two 32-bit timing words. A separate copy of both words is held for each chip select. A select command copies one chip's pair into the active timing registers, and every later cycle uses the active pair. The read-data sample point is counted from the falling edge of the read strobe and does not depend on the read pulse width. A status word mirrors the device ready/busy pin after synchronization.

Back-pressure rules: `req_ready` is high only while no cycle is in flight. A request moves only on a clock edge where `req_valid` and `req_ready` are both high. The response holds `rsp_valid` and `rsp_rdata` steady until a clock edge where `rsp_ready` is high, and only after that edge can the next request be accepted.

Top module: `nand_cycle_gen`

## Requirements
- R1: Request address bits [9:8] pick the chip select. Window offset 0x00 written is a command cycle with CLE high, 0x04 written is an address cycle with ALE high, and 0x08 is a data write or data read. Any other offset, and a read of 0x00 or 0x04, causes no strobe or chip-enable activity and gives a response after one busy cycle.
- R2: Write cycle with WC = max(word1[15:8],1), WH = max(word1[7:0],1) and WX = max(word1[23:16],1). WE# is low for WC-WH ticks (or 1 tick if WH >= WC), then high for WH ticks with the data still driven. After that comes WX ticks with CE# low and the bus released, and then the response.
- R3: Read cycle: CE# is low with RE# high for max(word1[31:24],1) ticks, then RE# is low for max(word2[15:8],1) ticks, high for max(word2[23:16],1) ticks, and turnaround for max(word2[7:0],1) ticks. The block never drives the bus during a read.
- R4: Read data is captured on the edge that ends tick A = max(word2[31:24],1), counted from the first tick with RE# low. If A is longer than the whole read phase, capture happens on the edge that ends the last turnaround tick.
- R5: A timing field of zero behaves as one tick. With all-zero timing, a write holds CE# low for 3 ticks and a read for 4.
- R6: After reset every stored and active timing word is zero. A configuration write stores both words for one chip select.
- R7: A select command loads the chosen chip's stored words into the active registers. A configuration write on its own leaves the active timing unchanged, and selecting another chip leaves each chip's stored words intact.
- R8: status[31] shows the ready/busy pin two clock edges after it changes. The other status bits read 0.
- R9: Only one cycle is in flight. req_ready is low from acceptance until the response is taken, and the response stays valid and stable while rsp_ready is low.
- R10: At most one CE# is low, and only during a cycle. WE# and RE# are never low together, CLE and ALE are never high together, and the bus is not driven while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Chip window [9:8], offset [7:0] |
| req_wdata | input | 8 | Byte for command, address or data write |
| rsp_valid | output | 1 | Cycle complete |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Captured read byte |
| cfg_valid | input | 1 | Store timing words for one chip |
| cfg_cs | input | 2 | Chip whose stored words are written |
| cfg_word1 | input | 32 | Ready delay, write extension, write cycle, write high |
| cfg_word2 | input | 32 | Access, read high, read low, read turnaround |
| sel_valid | input | 1 | Load a chip's stored words into active timing |
| sel_cs | input | 2 | Chip to select |
| status | output | 32 | Bit 31 = device ready |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus value when driven |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Device ready/busy, 1 = ready |

## Verification
Command, address and data writes are issued first with the all-zero reset timing and then with programmed timing. Their strobe widths, latch-enable choice and busy length show whether the minimum-tick rule and the write phases are both right. Reads are run with the access point inside the pulse and beyond the end of the read phase, while the bench bus changes its value every tick, so the captured byte shows exactly which edge sampled it. Cases with write-high at least as long as the cycle, with unused offsets, with timing stored before it is selected, and with a stalled response each exercise a different corner of the decode, timing selection and handshake logic.

// File: rtl/nandcg_pkg.sv
package nandcg_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_WEXT, S_RSET, S_RLOW, S_RHIGH, S_REXT, S_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE, K_CMD, K_ADR, K_WR, K_RD
  } op_kind_t;
endpackage

// File: rtl/nandcg_timing_bank.sv
module nandcg_timing_bank #(
  parameter int CS_NUM = 4,
  parameter int WORD_W = 32,
  localparam int CS_W = $clog2(CS_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [WORD_W-1:0] cfg_word1,
  input  logic [WORD_W-1:0] cfg_word2,
  input  logic              sel_valid,
  input  logic [CS_W-1:0]   sel_cs,
  output logic [WORD_W-1:0] act_word1,
  output logic [WORD_W-1:0] act_word2
);
  logic [WORD_W-1:0] st1 [CS_NUM];
  logic [WORD_W-1:0] st2 [CS_NUM];

  for (genvar g = 0; g < CS_NUM; g++) begin : g_chip
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1[g] <= '0;
        st2[g] <= '0;
      end else if (cfg_valid && cfg_cs == CS_W'(g)) begin
        st1[g] <= cfg_word1;
        st2[g] <= cfg_word2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_word1 <= '0;
      act_word2 <= '0;
    end else if (sel_valid) begin
      act_word1 <= st1[sel_cs];
      act_word2 <= st2[sel_cs];
    end
  end
endmodule

// File: rtl/nandcg_sync.sv
module nandcg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nandcg_seq.sv
module nandcg_seq
  import nandcg_pkg::*;
#(
  parameter int CS_NUM  = 4,
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 8,
  parameter int WIN_W   = 8,
  localparam int CS_W   = $clog2(CS_NUM),
  localparam int ADDR_W = CS_W + WIN_W,
  localparam int WORD_W = 4 * FIELD_W,
  localparam int EL_W   = FIELD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [WORD_W-1:0] t1,
  input  logic [WORD_W-1:0] t2,
  output logic [CS_NUM-1:0] ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  function automatic logic [FIELD_W-1:0] nz(input logic [FIELD_W-1:0] v);
    return (v == '0) ? FIELD_W'(1) : v;
  endfunction

  // Active fields, zero promoted to one tick
  logic [FIELD_W-1:0] rdy_n, wx_n, wc_n, wh_n, acc_n, rh_n, rpw_n, rx_n, wlo_n;
  assign rdy_n = nz(t1[4*FIELD_W-1:3*FIELD_W]);
  assign wx_n  = nz(t1[3*FIELD_W-1:2*FIELD_W]);
  assign wc_n  = nz(t1[2*FIELD_W-1:FIELD_W]);
  assign wh_n  = nz(t1[FIELD_W-1:0]);
  assign acc_n = nz(t2[4*FIELD_W-1:3*FIELD_W]);
  assign rh_n  = nz(t2[3*FIELD_W-1:2*FIELD_W]);
  assign rpw_n = nz(t2[2*FIELD_W-1:FIELD_W]);
  assign rx_n  = nz(t2[FIELD_W-1:0]);
  assign wlo_n = (wc_n > wh_n) ? (wc_n - wh_n) : FIELD_W'(1);

  seq_state_t         st;
  op_kind_t           kind_q, dec;
  logic [FIELD_W-1:0] cnt;
  logic [EL_W-1:0]    el;
  logic               got;
  logic [CS_W-1:0]    cs_q;
  logic [DATA_W-1:0]  wd_q, rd_q;
  logic               rd_ph, last;

  always_comb begin
    dec = K_NONE;
    unique case (req_addr[WIN_W-1:0])
      WIN_W'(0): if (req_write) dec = K_CMD;
      WIN_W'(4): if (req_write) dec = K_ADR;
      WIN_W'(8): dec = req_write ? K_WR : K_RD;
      default:   dec = K_NONE;
    endcase
  end

  assign rd_ph = (st == S_RLOW) || (st == S_RHIGH) || (st == S_REXT);
  assign last  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind_q <= K_NONE;
      cnt    <= '0;
      el     <= '0;
      got    <= 1'b0;
      cs_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      if (rd_ph) begin
        el <= el + 1'b1;
        if (!got && (el == EL_W'(acc_n) || (st == S_REXT && last))) begin
          rd_q <= dq_in;
          got  <= 1'b1;
        end
      end
      unique case (st)
        S_IDLE: if (req_valid) begin
          cs_q   <= req_addr[ADDR_W-1:WIN_W];
          wd_q   <= req_wdata;
          kind_q <= dec;
          got    <= 1'b0;
          if (dec == K_NONE)    st <= S_DONE;
          else if (dec == K_RD) begin st <= S_RSET; cnt <= rdy_n - 1'b1; end
          else                  begin st <= S_WLOW; cnt <= wlo_n - 1'b1; end
        end
        S_WLOW:  if (last) begin st <= S_WHIGH; cnt <= wh_n - 1'b1; end else cnt <= cnt - 1'b1;
        S_WHIGH: if (last) begin st <= S_WEXT;  cnt <= wx_n - 1'b1; end else cnt <= cnt - 1'b1;
        S_WEXT:  if (last) st <= S_DONE; else cnt <= cnt - 1'b1;
        S_RSET:  if (last) begin st <= S_RLOW; cnt <= rpw_n - 1'b1; el <= EL_W'(1); end
                 else cnt <= cnt - 1'b1;
        S_RLOW:  if (last) begin st <= S_RHIGH; cnt <= rh_n - 1'b1; end else cnt <= cnt - 1'b1;
        S_RHIGH: if (last) begin st <= S_REXT;  cnt <= rx_n - 1'b1; end else cnt <= cnt - 1'b1;
        S_REXT:  if (last) st <= S_DONE; else cnt <= cnt - 1'b1;
        S_DONE:  if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // Pin decode from the registered state
  logic active, wdrive;
  assign active = (st != S_IDLE) && (st != S_DONE);
  assign wdrive = (st == S_WLOW) || (st == S_WHIGH);

  for (genvar g = 0; g < CS_NUM; g++) begin : g_ce
    assign ce_n[g] = !(active && cs_q == CS_W'(g));
  end

  assign cle       = wdrive && (kind_q == K_CMD);
  assign ale       = wdrive && (kind_q == K_ADR);
  assign we_n      = (st != S_WLOW);
  assign re_n      = (st != S_RLOW);
  assign dq_oe     = wdrive;
  assign dq_out    = wd_q;
  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen #(
  parameter int CS_NUM  = 4,
  parameter int FIELD_W = 8,
  parameter int DATA_W  = 8,
  parameter int WIN_W   = 8,
  parameter int SYNC_N  = 2,
  localparam int CS_W   = $clog2(CS_NUM),
  localparam int ADDR_W = CS_W + WIN_W,
  localparam int WORD_W = 4 * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_valid,
  input  logic [CS_W-1:0]   cfg_cs,
  input  logic [WORD_W-1:0] cfg_word1,
  input  logic [WORD_W-1:0] cfg_word2,
  input  logic              sel_valid,
  input  logic [CS_W-1:0]   sel_cs,
  output logic [WORD_W-1:0] status,
  output logic [CS_NUM-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  logic [WORD_W-1:0] act1, act2;
  logic              rb_q;

  nandcg_timing_bank #(.CS_NUM(CS_NUM), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_cs(cfg_cs), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2),
    .sel_valid(sel_valid), .sel_cs(sel_cs),
    .act_word1(act1), .act_word2(act2)
  );

  nandcg_sync #(.STAGES(SYNC_N)) u_rb (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_q)
  );

  nandcg_seq #(.CS_NUM(CS_NUM), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .t1(act1), .t2(act2),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe), .dq_in(nand_dq_in)
  );

  assign status = {rb_q, {(WORD_W-1){1'b0}}};
endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
  parameter int CS_NUM = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [CS_NUM-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_dq_oe
);
  p_one_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nand_ce_n) <= 1);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_no_drive_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe && !rsp_valid));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && !req_ready));

  p_we_under_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_dq_oe && !(&nand_ce_n)));
endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(.CS_NUM(CS_NUM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .nand_ce_n(nand_ce_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_cycle_gen.sv
`timescale 1ns/1ps
module sim_nand_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [9:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [7:0]  rsp_rdata;
  logic        cfg_valid = 1'b0, sel_valid = 1'b0;
  logic [1:0]  cfg_cs = '0, sel_cs = '0;
  logic [31:0] cfg_word1 = '0, cfg_word2 = '0;
  logic [31:0] status;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in = '0;
  logic        nand_rb = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nand_cycle_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_cs(cfg_cs), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2),
    .sel_valid(sel_valid), .sel_cs(sel_cs), .status(status),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic store(input logic [1:0] cs, input logic [31:0] w1, input logic [31:0] w2);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_cs = cs; cfg_word1 = w1; cfg_word2 = w2;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic select(input logic [1:0] cs);
    @(negedge clk);
    sel_valid = 1'b1; sel_cs = cs;
    @(negedge clk);
    sel_valid = 1'b0;
  endtask

  // One request; tallies the pins on each tick until the response is taken.
  task automatic run_cycle(input string req, input bit wr, input logic [9:0] addr,
                           input logic [7:0] wd, input int e_we, input int e_re,
                           input int e_cle, input int e_ale, input int e_oe,
                           input int e_ce, input int e_busy, input bit rd_chk,
                           input int e_rd);
    int n_we = 0, n_re = 0, n_cle = 0, n_ale = 0, n_oe = 0, n_ce = 0, n_busy = 0;
    int n_other = 0, k = 0, wd_seen = -1;
    int cs = int'(addr[9:8]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    nand_dq_in = 8'h40;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (!nand_we_n) begin n_we++; if (wd_seen < 0) wd_seen = int'(nand_dq_out); end
      if (!nand_re_n) n_re++;
      if (nand_cle) n_cle++;
      if (nand_ale) n_ale++;
      if (nand_dq_oe) n_oe++;
      if (!nand_ce_n[cs]) n_ce++;
      if (((~nand_ce_n) & ~(4'b1 << cs)) != 4'b0) n_other++;
      if (!req_ready) n_busy++;
      if (rsp_valid) break;
      if (!nand_re_n || k > 0) k++;
      nand_dq_in = 8'h40 + 8'(k);
      @(negedge clk);
    end
    chk(req, "we_low_ticks", n_we, e_we);
    chk(req, "re_low_ticks", n_re, e_re);
    chk(req, "cle_ticks", n_cle, e_cle);
    chk(req, "ale_ticks", n_ale, e_ale);
    chk(req, "drive_ticks", n_oe, e_oe);
    chk(req, "ce_low_ticks", n_ce, e_ce);
    chk("R10", "other_ce_low", n_other, 0);
    chk(req, "busy_ticks", n_busy, e_busy);
    if (e_we > 0) chk(req, "dq_out_at_we", wd_seen, int'(wd));
    if (rd_chk) chk(req, "read_data", int'(rsp_rdata), e_rd);
  endtask

  task automatic t_reset;
    chk("R9", "reset req_ready", int'(req_ready), 1);
    chk("R9", "reset rsp_valid", int'(rsp_valid), 0);
    chk("R10", "reset ce_n", int'(nand_ce_n), 15);
    chk("R10", "reset strobes", int'({nand_we_n, nand_re_n, nand_dq_oe}), 6);
    chk("R8", "reset status", int'(status), 0);
  endtask

  task automatic t_zero_timing;
    // R5: all fields zero -> every phase one tick
    run_cycle("R5", 1'b1, 10'h000, 8'h70, 1, 0, 2, 0, 2, 3, 4, 1'b0, 0);
    run_cycle("R5", 1'b0, 10'h008, 8'h00, 0, 1, 0, 0, 0, 4, 5, 1'b1, 8'h41);
  endtask

  task automatic t_store_not_active;
    // R6/R7: word1 {rdy=2,wx=3,wc=6,wh=2}, word2 {acc=3,rh=2,rpw=4,rx=1}
    store(2'd1, 32'h02_03_06_02, 32'h03_02_04_01);
    run_cycle("R7", 1'b1, 10'h100, 8'h5A, 1, 0, 2, 0, 2, 3, 4, 1'b0, 0);
  endtask

  task automatic t_programmed_write;
    select(2'd1);
    run_cycle("R2", 1'b1, 10'h100, 8'hA5, 4, 0, 6, 0, 6, 9, 10, 1'b0, 0);
    run_cycle("R1", 1'b1, 10'h104, 8'h3C, 4, 0, 0, 6, 6, 9, 10, 1'b0, 0);
    run_cycle("R1", 1'b1, 10'h108, 8'hC3, 4, 0, 0, 0, 6, 9, 10, 1'b0, 0);
  endtask

  task automatic t_programmed_read;
    // R3/R4: sample at tick 3 after RE# falls
    run_cycle("R4", 1'b0, 10'h108, 8'h00, 0, 4, 0, 0, 0, 9, 10, 1'b1, 8'h43);
  endtask

  task automatic t_late_sample_and_long_high;
    // chip 2: word1 {0,0,wc=2,wh=5}; word2 {acc=20,rh=1,rpw=2,rx=1}
    store(2'd2, 32'h00_00_02_05, 32'h14_01_02_01);
    select(2'd2);
    run_cycle("R2", 1'b1, 10'h200, 8'h11, 1, 0, 6, 0, 6, 7, 8, 1'b0, 0);
    run_cycle("R4", 1'b0, 10'h208, 8'h00, 0, 2, 0, 0, 0, 5, 6, 1'b1, 8'h44);
  endtask

  task automatic t_ignored_offsets;
    run_cycle("R1", 1'b1, 10'h10C, 8'hFF, 0, 0, 0, 0, 0, 0, 1, 1'b0, 0);
    run_cycle("R1", 1'b0, 10'h300, 8'h00, 0, 0, 0, 0, 0, 0, 1, 1'b0, 0);
    run_cycle("R1", 1'b0, 10'h004, 8'h00, 0, 0, 0, 0, 0, 0, 1, 1'b0, 0);
  endtask

  task automatic t_reselect_keeps_store;
    select(2'd1);
    run_cycle("R7", 1'b1, 10'h300, 8'h22, 4, 0, 6, 0, 6, 9, 10, 1'b0, 0);
  endtask

  task automatic t_status;
    @(negedge clk); nand_rb = 1'b1;
    @(negedge clk);
    chk("R8", "status after one edge", int'(status[31]), 0);
    @(negedge clk);
    chk("R8", "status after two edges", int'(status), 32'h8000_0000);
    nand_rb = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8", "status cleared", int'(status), 0);
  endtask

  task automatic t_rsp_stall;
    int held;
    int ok = 1;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h108;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_valid; i++) @(negedge clk);
    held = int'(rsp_rdata);
    for (int i = 0; i < 4; i++) begin
      nand_dq_in = nand_dq_in + 8'd7;
      @(negedge clk);
      if (!rsp_valid || req_ready || int'(rsp_rdata) != held) ok = 0;
    end
    chk("R9", "response held while stalled", ok, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9", "idle after response taken", int'({req_ready, rsp_valid}), 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_timing();
    t_store_not_active();
    t_programmed_write();
    t_programmed_read();
    t_late_sample_and_long_high();
    t_ignored_offsets();
    t_reselect_keeps_store();
    t_status();
    t_rsp_stall();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule